// File: doc/BRIEF.md
# Banked-Register Exception Entry Unit

This block keeps a small part of a processor's architectural state: the status word with its mode field and interrupt-disable bit, the saved status word, the stack register, the link register and the program counter. It also keeps one private copy of the stack register, link register and saved status word for each privilege bank. When the mode changes, these three registers are exchanged with the bank of the new mode.

An exception request names one of four exception kinds. In one clock cycle the unit picks the target mode and exchanges the banked registers if the mode changes. It then copies the old status word into the saved status word, writes the new mode and sets interrupt-disable. The link register takes the current program counter, and the program counter jumps to a vector. A separate mode-set input performs the same bank exchange without an exception entry. A plain write port loads the stack, link, saved status and program counter registers. Illegal requests do not halt anything. They raise a sticky error flag and leave the state untouched.

Top module: `excEntryUnit`

## Requirements
- R1: After reset the status word is 0x00000013 (privileged mode, interrupt-disable clear). The saved status, stack, link and program counter registers are 0, and `errFlag` is 0.
- R2: Mode encodings in status bits [4:0] are user 0x10, system 0x1F, privileged 0x13, trap 0x17 and interrupt 0x12. Exception kind 0 (privileged call) enters 0x13. Kinds 1 (fetch fault) and 2 (data fault) enter 0x17. Kind 3 (external interrupt) enters 0x12.
- R3: The vector is a base plus an offset. The base is 0x00000000 when `vecHigh` is 0 and 0xFFFF0000 when it is 1. The offsets are 0x08 for kind 0, 0x0C for kind 1, 0x10 for kind 2 and 0x18 for kind 3.
- R4: On exception entry the link register takes the program counter as it was before entry, and the program counter takes the vector. Both happen at the same clock edge.
- R5: On exception entry the saved status word takes the complete old status word. The status mode field becomes the target mode and bit 7 (interrupt-disable) is set.
- R6: On a mode change, the current stack, link and saved status values are stored first into the old mode's bank. The three registers are then loaded from the new mode's bank. In an exception entry, the loaded link and saved status values are then replaced as R4 and R5 state.
- R7: If the target mode equals the current mode, no exchange takes place and the stack register keeps its value.
- R8: User and system modes share one bank. Switching between them leaves the stack, link and saved status registers unchanged.
- R9: `modeSet` with a known `modeIn` performs the R6 exchange and writes the mode field. Bit 7 and the program counter are left unchanged.
- R10: An exception kind of 4 to 7, or `modeSet` with an unknown `modeIn`, sets `errFlag` and changes no register. `errFlag` stays set until reset.
- R11: Priority is `excReq`, then `modeSet`, then `wrEn`. Only the highest active request takes effect in a cycle.
- R12: `wrEn` writes `wrData` into the register chosen by `wrSel`: 0 stack, 1 link, 2 program counter, 3 saved status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Exception entry request |
| excType | input | 3 | Exception kind |
| vecHigh | input | 1 | Vector base select |
| modeSet | input | 1 | Mode switch request |
| modeIn | input | 5 | Requested mode for `modeSet` |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register write target |
| wrData | input | 32 | Register write value |
| statusWord | output | 32 | Current status word |
| savedStatus | output | 32 | Saved status word |
| stackReg | output | 32 | Stack register |
| linkReg | output | 32 | Link register |
| progCtr | output | 32 | Program counter |
| errFlag | output | 1 | Sticky illegal-request flag |

## Verification
An exception entry can arrive in the same cycle as a mode switch and a register write. The bench raises all three at one clock edge. It then confirms that the stack value came from the interrupt bank and not from `wrData`, and that the mode is the exception's target and not `modeIn`. A second cycle pairs a mode switch with a write and expects the stack value loaded from the bank to win.

// File: rtl/excEntryPkg.sv
`timescale 1ns/1ps
package excEntryPkg;
  parameter int DATA_W    = 32;
  parameter int MODE_W    = 5;
  parameter int NUM_BANKS = 4;
  parameter int IDIS_BIT  = 7;
  localparam int BANK_W   = $clog2(NUM_BANKS);

  localparam logic [MODE_W-1:0] MODE_USER = 5'h10;
  localparam logic [MODE_W-1:0] MODE_SYS  = 5'h1F;
  localparam logic [MODE_W-1:0] MODE_PRIV = 5'h13;
  localparam logic [MODE_W-1:0] MODE_TRAP = 5'h17;
  localparam logic [MODE_W-1:0] MODE_INTR = 5'h12;

  localparam logic [DATA_W-1:0] OFF_PCALL  = 32'h08;
  localparam logic [DATA_W-1:0] OFF_IFAULT = 32'h0C;
  localparam logic [DATA_W-1:0] OFF_DFAULT = 32'h10;
  localparam logic [DATA_W-1:0] OFF_IRQ    = 32'h18;

  typedef enum logic [2:0] {
    KIND_PCALL  = 3'd0,
    KIND_IFAULT = 3'd1,
    KIND_DFAULT = 3'd2,
    KIND_IRQ    = 3'd3
  } excKind_e;

  typedef struct packed {
    logic              doExc;
    logic              doModeSet;
    logic              doWr;
    logic              doSwap;
    logic [MODE_W-1:0] newMode;
    logic [BANK_W-1:0] oldIdx;
    logic [BANK_W-1:0] newIdx;
    logic [DATA_W-1:0] vector;
  } strobe_t;

  function automatic logic modeKnown(input logic [MODE_W-1:0] m);
    return (m == MODE_USER) || (m == MODE_SYS) || (m == MODE_PRIV) ||
           (m == MODE_TRAP) || (m == MODE_INTR);
  endfunction

  function automatic logic [BANK_W-1:0] modeBank(input logic [MODE_W-1:0] m);
    case (m)
      MODE_PRIV: return BANK_W'(1);
      MODE_TRAP: return BANK_W'(2);
      MODE_INTR: return BANK_W'(3);
      default:   return BANK_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/excEntryCtrl.sv
`timescale 1ns/1ps
module excEntryCtrl
  import excEntryPkg::*;
#(
  parameter logic [DATA_W-1:0] HIGH_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [2:0]        excType,
  input  logic              vecHigh,
  input  logic              modeSet,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              wrEn,
  input  logic [MODE_W-1:0] curMode,
  output strobe_t           strb,
  output logic              errFlag
);
  logic              excOk;
  logic [MODE_W-1:0] excMode;
  logic [DATA_W-1:0] excOff;
  logic              modeOk;
  logic              errNext;

  always_comb begin
    excOk   = 1'b1;
    excMode = MODE_PRIV;
    excOff  = OFF_PCALL;
    case (excType)
      KIND_PCALL:  begin excMode = MODE_PRIV; excOff = OFF_PCALL;  end
      KIND_IFAULT: begin excMode = MODE_TRAP; excOff = OFF_IFAULT; end
      KIND_DFAULT: begin excMode = MODE_TRAP; excOff = OFF_DFAULT; end
      KIND_IRQ:    begin excMode = MODE_INTR; excOff = OFF_IRQ;    end
      default:     excOk = 1'b0;
    endcase
  end

  assign modeOk = modeKnown(modeIn);

  always_comb begin
    strb           = '0;
    strb.doExc     = excReq & excOk;
    strb.doModeSet = ~excReq & modeSet & modeOk;
    strb.doWr      = ~excReq & ~modeSet & wrEn;
    strb.newMode   = excReq ? excMode : modeIn;
    strb.oldIdx    = modeBank(curMode);
    strb.newIdx    = modeBank(strb.newMode);
    strb.doSwap    = (strb.doExc | strb.doModeSet) && (strb.newMode != curMode);
    strb.vector    = (vecHigh ? HIGH_BASE : '0) | excOff;
  end

  assign errNext = (excReq & ~excOk) | (~excReq & modeSet & ~modeOk);

  always_ff @(posedge clk) begin
    if (!rstN)        errFlag <= 1'b0;
    else if (errNext) errFlag <= 1'b1;
  end

  assert_one_action_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doExc, strb.doModeSet, strb.doWr}));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

// File: rtl/excEntryDatapath.sv
`timescale 1ns/1ps
module excEntryDatapath
  import excEntryPkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_MODE = 5'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] savedStatus,
  output logic [DATA_W-1:0] stackReg,
  output logic [DATA_W-1:0] linkReg,
  output logic [DATA_W-1:0] progCtr
);
  logic [DATA_W-1:0] bankSp  [NUM_BANKS];
  logic [DATA_W-1:0] bankLr  [NUM_BANKS];
  logic [DATA_W-1:0] bankSps [NUM_BANKS];
  logic [DATA_W-1:0] loadSp, loadLr, loadSps;
  logic              sameBank;

  // Store into the old bank happens before the load: a shared bank forwards live values.
  assign sameBank = (strb.oldIdx == strb.newIdx);
  assign loadSp   = sameBank ? stackReg    : bankSp[strb.newIdx];
  assign loadLr   = sameBank ? linkReg     : bankLr[strb.newIdx];
  assign loadSps  = sameBank ? savedStatus : bankSps[strb.newIdx];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankSp[g]  <= '0;
        bankLr[g]  <= '0;
        bankSps[g] <= '0;
      end else if (strb.doSwap && strb.oldIdx == BANK_W'(g)) begin
        bankSp[g]  <= stackReg;
        bankLr[g]  <= linkReg;
        bankSps[g] <= savedStatus;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusWord  <= DATA_W'(RESET_MODE);
      savedStatus <= '0;
      stackReg    <= '0;
      linkReg     <= '0;
      progCtr     <= '0;
    end else if (strb.doExc) begin
      if (strb.doSwap) stackReg <= loadSp;
      savedStatus            <= statusWord;
      statusWord[MODE_W-1:0] <= strb.newMode;
      statusWord[IDIS_BIT]   <= 1'b1;
      linkReg                <= progCtr;
      progCtr                <= strb.vector;
    end else if (strb.doModeSet) begin
      if (strb.doSwap) begin
        stackReg    <= loadSp;
        linkReg     <= loadLr;
        savedStatus <= loadSps;
      end
      statusWord[MODE_W-1:0] <= strb.newMode;
    end else if (strb.doWr) begin
      case (wrSel)
        2'd0:    stackReg    <= wrData;
        2'd1:    linkReg     <= wrData;
        2'd2:    progCtr     <= wrData;
        default: savedStatus <= wrData;
      endcase
    end
  end

  assert_pc_vector_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.doExc |=> progCtr == $past(strb.vector));

  assert_link_pc_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.doExc |=> linkReg == $past(progCtr));

  assert_saved_status_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.doExc |=> savedStatus == $past(statusWord));

  assert_idis_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.doExc |=> statusWord[IDIS_BIT]);

  assert_mode_written_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doExc || strb.doModeSet) |=> statusWord[MODE_W-1:0] == $past(strb.newMode));

  assert_no_swap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doExc && !strb.doSwap) |=> stackReg == $past(stackReg));
endmodule

// File: rtl/excEntryUnit.sv
`timescale 1ns/1ps
module excEntryUnit
  import excEntryPkg::*;
#(
  parameter logic [DATA_W-1:0] HIGH_BASE  = 32'hFFFF_0000,
  parameter logic [MODE_W-1:0] RESET_MODE = 5'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [2:0]        excType,
  input  logic              vecHigh,
  input  logic              modeSet,
  input  logic [4:0]        modeIn,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [31:0]       wrData,
  output logic [31:0]       statusWord,
  output logic [31:0]       savedStatus,
  output logic [31:0]       stackReg,
  output logic [31:0]       linkReg,
  output logic [31:0]       progCtr,
  output logic              errFlag
);
  strobe_t strb;

  excEntryCtrl #(.HIGH_BASE(HIGH_BASE)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .excReq  (excReq),
    .excType (excType),
    .vecHigh (vecHigh),
    .modeSet (modeSet),
    .modeIn  (modeIn),
    .wrEn    (wrEn),
    .curMode (statusWord[MODE_W-1:0]),
    .strb    (strb),
    .errFlag (errFlag)
  );

  excEntryDatapath #(.RESET_MODE(RESET_MODE)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrSel       (wrSel),
    .wrData      (wrData),
    .statusWord  (statusWord),
    .savedStatus (savedStatus),
    .stackReg    (stackReg),
    .linkReg     (linkReg),
    .progCtr     (progCtr)
  );
endmodule

// File: tb/excEntryUnit_tb_top.sv
`timescale 1ns/1ps
module excEntryUnit_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        excReq, vecHigh, modeSet, wrEn, errFlag;
  logic [2:0]  excType;
  logic [4:0]  modeIn;
  logic [1:0]  wrSel;
  logic [31:0] wrData, statusWord, savedStatus, stackReg, linkReg, progCtr;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  excEntryUnit dut_i (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excType(excType), .vecHigh(vecHigh),
    .modeSet(modeSet), .modeIn(modeIn), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .statusWord(statusWord), .savedStatus(savedStatus), .stackReg(stackReg),
    .linkReg(linkReg), .progCtr(progCtr), .errFlag(errFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkAll(input string tag, input logic [31:0] st, input logic [31:0] sps,
                        input logic [31:0] sp, input logic [31:0] lr, input logic [31:0] pc);
    chk({tag, " status"}, statusWord, st);
    chk({tag, " saved"}, savedStatus, sps);
    chk({tag, " stack"}, stackReg, sp);
    chk({tag, " link"}, linkReg, lr);
    chk({tag, " pc"}, progCtr, pc);
  endtask

  task automatic idle();
    excReq = 0; excType = 0; vecHigh = 0; modeSet = 0; modeIn = 0;
    wrEn = 0; wrSel = 0; wrData = 0;
  endtask

  task automatic doReset();
    idle();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic write(input logic [1:0] sel, input logic [31:0] val);
    wrEn = 1; wrSel = sel; wrData = val;
    @(negedge clk);
    idle();
  endtask

  task automatic setMode(input logic [4:0] m);
    modeSet = 1; modeIn = m;
    @(negedge clk);
    idle();
  endtask

  task automatic raise(input logic [2:0] kind, input logic hi);
    excReq = 1; excType = kind; vecHigh = hi;
    @(negedge clk);
    idle();
  endtask

  task automatic testReset();
    doReset();
    chkAll("R1 reset", 32'h13, 0, 0, 0, 0);
    chk("R1 errFlag", {31'b0, errFlag}, 0);
  endtask

  task automatic testWrites();
    write(2'd0, 32'hA1); write(2'd1, 32'hA2); write(2'd3, 32'hA3); write(2'd2, 32'h1000);
    chkAll("R12 writes", 32'h13, 32'hA3, 32'hA1, 32'hA2, 32'h1000);
  endtask

  task automatic testModeSwitch();
    setMode(5'h10);
    chkAll("R9 to user", 32'h10, 0, 0, 0, 32'h1000);
    write(2'd0, 32'hB1); write(2'd1, 32'hB2); write(2'd3, 32'hB3);
    setMode(5'h1F);
    chkAll("R8 user to system", 32'h1F, 32'hB3, 32'hB1, 32'hB2, 32'h1000);
    setMode(5'h13);
    chkAll("R6 back to priv", 32'h13, 32'hA3, 32'hA1, 32'hA2, 32'h1000);
  endtask

  task automatic testEntries();
    write(2'd2, 32'h2000);
    raise(3'd3, 1'b0);
    chkAll("R2 R3 R4 R5 R6 irq entry", 32'h92, 32'h13, 0, 32'h2000, 32'h18);
    write(2'd0, 32'hC1);
    raise(3'd3, 1'b1);
    chkAll("R7 irq in irq", 32'h92, 32'h92, 32'hC1, 32'h18, 32'hFFFF0018);
    raise(3'd1, 1'b1);
    chkAll("R2 R3 fetch fault", 32'h97, 32'h92, 0, 32'hFFFF0018, 32'hFFFF000C);
    raise(3'd2, 1'b1);
    chkAll("R2 R3 R7 data fault", 32'h97, 32'h97, 0, 32'hFFFF000C, 32'hFFFF0010);
    setMode(5'h12);
    chkAll("R6 R9 restore irq bank", 32'h92, 32'h92, 32'hC1, 32'h18, 32'hFFFF0010);
    raise(3'd0, 1'b0);
    chkAll("R2 R3 priv call", 32'h93, 32'h92, 32'hA1, 32'hFFFF0010, 32'h08);
  endtask

  task automatic testPriority();
    excReq = 1; excType = 3'd3; modeSet = 1; modeIn = 5'h10;
    wrEn = 1; wrSel = 2'd0; wrData = 32'hDEAD;
    @(negedge clk);
    idle();
    chkAll("R11 exc beats set and write", 32'h92, 32'h93, 32'hC1, 32'h08, 32'h18);
    modeSet = 1; modeIn = 5'h13; wrEn = 1; wrSel = 2'd0; wrData = 32'h55;
    @(negedge clk);
    idle();
    chk("R11 set beats write stack", stackReg, 32'hA1);
    chk("R11 set beats write status", statusWord, 32'h93);
  endtask

  task automatic testErrors();
    logic [31:0] st, sps, sp, lr, pc;
    st = statusWord; sps = savedStatus; sp = stackReg; lr = linkReg; pc = progCtr;
    raise(3'd5, 1'b1);
    chk("R10 bad kind flag", {31'b0, errFlag}, 1);
    chkAll("R10 bad kind no change", st, sps, sp, lr, pc);
    @(negedge clk);
    chk("R10 sticky", {31'b0, errFlag}, 1);
    doReset();
    chk("R10 R1 cleared by reset", {31'b0, errFlag}, 0);
    setMode(5'h0A);
    chk("R10 bad mode flag", {31'b0, errFlag}, 1);
    chkAll("R10 bad mode no change", 32'h13, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 0;
    @(negedge clk);
    testReset();
    testWrites();
    testModeSwitch();
    testEntries();
    testPriority();
    testErrors();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule